// File: doc/BRIEF.md
# Last-In Byte Buffer with Occupancy-Selected Output

This block is a small register-based stack of bytes. Its capacity is a compile-time parameter (eight bytes by default). A push strobe stores the byte on the input in the next free slot. A pop strobe releases the newest slot. A counter records how many slots are occupied.

The output byte is taken from the slot picked by that occupancy counter, so it always shows the most recently stored byte that has not been popped. When nothing is held, the output is zero. The selection walks every slot and compares the counter with a constant for each one. No part select has a bound that depends on a run-time value, which keeps it friendly to synthesis. Requests that cannot be honoured leave the state unchanged and produce a single-cycle error pulse.

Top module: `byte_stack`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) sets occupancy to 0, empty to 1, full to 0, top_byte to 0, and clears both error pulses.
- R2: A push without pop while occupancy is below DEPTH stores push_data in slot number occupancy and adds one to occupancy; top_byte shows that byte after the edge.
- R3: A pop without push while occupancy is above zero subtracts one from occupancy; top_byte then shows the byte pushed before the popped one.
- R4: Push and pop together while occupancy is above zero overwrite the newest slot with push_data and leave occupancy unchanged.
- R5: A push without pop while occupancy equals DEPTH changes no stored byte and does not change occupancy; overflow is 1 for the single cycle after that edge.
- R6: A pop while occupancy is zero changes nothing except that underflow is 1 for the single cycle after that edge. When push is also high in the same cycle, the push takes effect as in R2.
- R7: empty is 1 exactly when occupancy is 0, and full is 1 exactly when occupancy equals DEPTH.
- R8: top_byte is all zeros whenever occupancy is 0.
- R9: Occupancy never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| push | input | 1 | Store push_data on this edge |
| push_data | input | DW | Byte to store |
| pop | input | 1 | Release the newest slot on this edge |
| top_byte | output | DW | Newest held byte, zero when empty |
| count | output | $clog2(DEPTH+1) | Number of bytes held |
| full | output | 1 | Occupancy equals DEPTH |
| empty | output | 1 | Occupancy is zero |
| overflow | output | 1 | One-cycle pulse after a refused push |
| underflow | output | 1 | One-cycle pulse after a refused pop |

## Verification
The hardest cases to reach are the two boundaries met with both strobes at once. Push and pop together on a full stack must overwrite the top slot without raising overflow. Push and pop together on an empty stack must store the byte and still raise underflow. Random traffic seldom stays at either end long enough to hit these, so the stimulus runs in phases: some phases favour pushes, some favour pops, and some keep both strobes high. Directed sequences also fill the stack to capacity and drain it completely before the random phases begin.

// File: rtl/byte_stack_pkg.sv
package byte_stack_pkg;
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_PUSH = 2'd1,
        ACT_POP  = 2'd2,
        ACT_SWAP = 2'd3
    } stack_act_e;
endpackage

// File: rtl/byte_stack_ctl.sv
module byte_stack_ctl
    import byte_stack_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CW    = 4
) (
    input  logic          push,
    input  logic          pop,
    input  logic [CW-1:0] level,
    output stack_act_e    act,
    output logic          is_full,
    output logic          is_empty,
    output logic          ovf,
    output logic          unf
);
    always_comb begin
        is_full  = (level == CW'(DEPTH));
        is_empty = (level == '0);
        ovf      = push && !pop && is_full;
        unf      = pop && is_empty;
        act      = ACT_HOLD;
        if (push && pop) begin
            act = is_empty ? ACT_PUSH : ACT_SWAP;
        end else if (push && !is_full) begin
            act = ACT_PUSH;
        end else if (pop && !is_empty) begin
            act = ACT_POP;
        end
    end
endmodule

// File: rtl/byte_stack_sel.sv
module byte_stack_sel #(
    parameter int DEPTH = 8,
    parameter int DW    = 8,
    parameter int CW    = 4
) (
    input  logic [DEPTH-1:0][DW-1:0] slots,
    input  logic [CW-1:0]            level,
    output logic [DW-1:0]            sel
);
    always_comb begin
        sel = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (level == CW'(i + 1)) begin
                sel = slots[i];
            end
        end
    end
endmodule

// File: rtl/byte_stack.sv
module byte_stack
    import byte_stack_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int DW    = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] top_byte,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty,
    output logic          overflow,
    output logic          underflow
);
    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] slots;
        logic [CW-1:0]            level;
        logic                     ovf;
        logic                     unf;
    } stack_state_t;

    stack_state_t st_d, st_q;
    stack_act_e   act;
    logic         ovf_now, unf_now;

    byte_stack_ctl #(.DEPTH(DEPTH), .CW(CW)) u_ctl (
        .push     (push),
        .pop      (pop),
        .level    (st_q.level),
        .act      (act),
        .is_full  (full),
        .is_empty (empty),
        .ovf      (ovf_now),
        .unf      (unf_now)
    );

    byte_stack_sel #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_sel (
        .slots (st_q.slots),
        .level (st_q.level),
        .sel   (top_byte)
    );

    always_comb begin
        st_d     = st_q;
        st_d.ovf = ovf_now;
        st_d.unf = unf_now;
        for (int i = 0; i < DEPTH; i++) begin
            if (act == ACT_PUSH && st_q.level == CW'(i)) begin
                st_d.slots[i] = push_data;
            end
            if (act == ACT_SWAP && st_q.level == CW'(i + 1)) begin
                st_d.slots[i] = push_data;
            end
        end
        case (act)
            ACT_PUSH: st_d.level = st_q.level + 1'b1;
            ACT_POP:  st_d.level = st_q.level - 1'b1;
            default:  st_d.level = st_q.level;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.slots <= '0;
            st_q.level <= '0;
            st_q.ovf   <= 1'b0;
            st_q.unf   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count     = st_q.level;
    assign overflow  = st_q.ovf;
    assign underflow = st_q.unf;
endmodule

// File: rtl/byte_stack_chk.sv
module byte_stack_chk #(
    parameter int DEPTH = 8,
    parameter int DW    = 8,
    parameter int CW    = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          push,
    input logic [DW-1:0] push_data,
    input logic          pop,
    input logic [DW-1:0] top_byte,
    input logic [CW-1:0] count,
    input logic          full,
    input logic          empty,
    input logic          overflow,
    input logic          underflow
);
    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (count == '0 && !overflow && !underflow));

    assert_push_grows_R2: assert property (@(posedge clk) disable iff (rst)
        (push && !pop && !full) |=> (count == $past(count) + 1'b1 && top_byte == $past(push_data)));

    assert_pop_shrinks_R3: assert property (@(posedge clk) disable iff (rst)
        (pop && !push && !empty) |=> (count == $past(count) - 1'b1));

    assert_swap_keeps_R4: assert property (@(posedge clk) disable iff (rst)
        (push && pop && !empty) |=> ($stable(count) && top_byte == $past(push_data) && !overflow));

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
        (push && !pop && full) |=> (overflow && $stable(count) && $stable(top_byte)));

    assert_underflow_R6: assert property (@(posedge clk) disable iff (rst)
        (pop && !push && empty) |=> (underflow && count == '0));

    assert_flags_excl_R7: assert property (@(posedge clk) disable iff (rst)
        !(full && empty));

    assert_empty_zero_R8: assert property (@(posedge clk) disable iff (rst)
        empty |-> (top_byte == '0));

    assert_bound_R9: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));
endmodule

bind byte_stack byte_stack_chk #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .push_data (push_data),
    .pop       (pop),
    .top_byte  (top_byte),
    .count     (count),
    .full      (full),
    .empty     (empty),
    .overflow  (overflow),
    .underflow (underflow)
);

// File: tb/byte_stack_test.sv
`timescale 1ns/1ps
module byte_stack_test;
    localparam int DEPTH = 8;
    localparam int DW    = 8;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst, push, pop;
    logic [DW-1:0] push_data;
    logic [DW-1:0] top_byte;
    logic [CW-1:0] count;
    logic          full, empty, overflow, underflow;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    logic [DW-1:0] mdl [DEPTH];
    int            mcnt;
    logic          exp_ovf, exp_unf;

    byte_stack #(.DEPTH(DEPTH), .DW(DW)) uut (
        .clk, .rst, .push, .push_data, .pop,
        .top_byte, .count, .full, .empty, .overflow, .underflow
    );

    always #2 clk = ~clk;
    always @(posedge clk) cycles <= cycles + 1;

    function automatic logic [DW-1:0] exp_top();
        return (mcnt == 0) ? '0 : mdl[mcnt-1];
    endfunction

    task automatic chk(input string req, input int act, input int expv);
        n_checks++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, expv, cycles);
        end
    endtask

    task automatic check_all();
        chk("R2/R3/R4/R9 count", int'(count), mcnt);
        chk(mcnt == 0 ? "R8 top_byte" : "R2/R3/R4 top_byte", int'(top_byte), int'(exp_top()));
        chk("R7 empty", int'(empty), int'(mcnt == 0));
        chk("R7 full", int'(full), int'(mcnt == DEPTH));
        chk("R5 overflow", int'(overflow), int'(exp_ovf));
        chk("R6 underflow", int'(underflow), int'(exp_unf));
    endtask

    task automatic step(input logic p, input logic [DW-1:0] d, input logic q);
        push = p; push_data = d; pop = q;
        exp_ovf = p && !q && mcnt == DEPTH;
        exp_unf = q && mcnt == 0;
        @(posedge clk);
        #1;
        if (p && q && mcnt > 0) mdl[mcnt-1] = d;
        else if (p && (q || mcnt < DEPTH)) begin mdl[mcnt] = d; mcnt++; end
        else if (q && !p && mcnt > 0) mcnt--;
        push = 0; pop = 0;
        check_all();
    endtask

    task automatic do_reset();
        rst = 1; push = 0; pop = 0; push_data = '0;
        @(posedge clk);
        #1;
        rst = 0;
        mcnt = 0; exp_ovf = 0; exp_unf = 0;
        // R1: state right after reset
        check_all();
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        do_reset();
        // R2: fill to capacity
        for (int i = 0; i < DEPTH; i++) step(1, DW'(8'hA0 + i), 0);
        // R5: push when full is refused
        step(1, 8'h5A, 0);
        step(1, 8'h5B, 0);
        // R4: swap on a full stack, no overflow
        step(1, 8'hC3, 1);
        // R3: drain in reverse order
        for (int i = 0; i < DEPTH; i++) step(0, 8'h00, 1);
        // R6: pop when empty, then push and pop together on empty
        step(0, 8'h00, 1);
        step(1, 8'h77, 1);
        step(0, 8'h00, 1);
        // R1: reset while partly filled
        step(1, 8'h11, 0);
        step(1, 8'h22, 0);
        do_reset();
        // phased random traffic
        for (int ph = 0; ph < 60; ph++) begin
            int mode = ph % 3;
            for (int k = 0; k < 20; k++) begin
                int r = $urandom_range(0, 99);
                logic p, q;
                case (mode)
                    0: begin p = r < 75; q = r >= 85; end
                    1: begin p = r >= 85; q = r < 75; end
                    default: begin p = r < 60; q = r >= 30; end
                endcase
                step(p, DW'($urandom), q);
            end
        end
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(4 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule